// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gated logic domain on or off by running a fixed sequence of handshaked steps. It drives the domain's two power switch enables, its isolation clamp, its active-low reset, its clock gate, one power-down line per SRAM bank, and a request that fences the domain off from the bus. It watches two independent power-status acknowledges and one power-down acknowledge per SRAM bank.

A one-cycle `req_valid` pulse starts a sequence, and `req_on` picks the direction. Each control output changes in a cycle of its own, so the order can be seen at the pins. The domain counts as powered only when both status acknowledges agree. A mixed pair means the switch is still settling. Every acknowledge wait is bounded by a cycle-count timeout. When the timeout expires, the sequence stops where it is and raises a sticky error flag. When a sequence completes, `done` pulses for one cycle.

Top module: `pd_gate_seq`

## Requirements
- R1: After reset the domain is held off: both power enables 0, `iso_en` 1, `dom_rst_n` 0, `clk_off` 1, every `sram_pd` bit 1, `bus_guard` 1, `done` 0 and `err` 0.
- R2: Power-up sets `pwr_main` in the clock edge that accepts the request, and sets `pwr_aux` one edge later, never in the same edge.
- R3: The power-up wait ends only when both `stat_ack_a` and `stat_ack_b` are 1. The power-down wait ends only when both are 0. A mixed pair keeps the sequencer waiting.
- R4: After the power wait, power-up clears `clk_off`, then clears `iso_en`, then raises `dom_rst_n`, then clears all `sram_pd` bits, each on a separate edge. In every cycle at most one control output (the `sram_pd` vector counted as one) changes.
- R5: Power-up then waits until every masked `sram_ack` bit is 0, drops `bus_guard` on the next step, and pulses `done` after that.
- R6: Power-down first raises `bus_guard`, then sets every `sram_pd` bit, then waits until every masked `sram_ack` bit is 1.
- R7: Power-down then sets `iso_en`, clears `dom_rst_n`, sets `clk_off`, clears `pwr_main` and clears `pwr_aux`, in that order on separate edges. It then waits for both status acknowledges to read 0 before it pulses `done`.
- R8: When the parameter `SRAM_ACK_MASK` is zero, both SRAM acknowledge waits are skipped, and `sram_ack` has no effect.
- R9: If a wait lasts `TIMEOUT_CYC` cycles without its condition, the sequence stops. `err` rises, `done` does not pulse and every control output keeps its value. `err` stays 1 until a new request is accepted, and that edge clears it.
- R10: A request that arrives while a sequence is running is ignored.
- R11: `done` is high for exactly one cycle per completed sequence and is never high together with `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start pulse, accepted only when idle |
| req_on | input | 1 | Direction: 1 power up, 0 power down |
| stat_ack_a | input | 1 | First power-status acknowledge |
| stat_ack_b | input | 1 | Second power-status acknowledge |
| sram_ack | input | SRAM_W | Per-bank SRAM power-down acknowledge |
| pwr_main | output | 1 | Primary power switch enable |
| pwr_aux | output | 1 | Secondary power switch enable |
| iso_en | output | 1 | Isolation clamp enable |
| dom_rst_n | output | 1 | Domain reset, active low |
| clk_off | output | 1 | Domain clock gate, 1 = stopped |
| sram_pd | output | SRAM_W | Per-bank SRAM power-down |
| bus_guard | output | 1 | Bus protection request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |

## Verification
A request driven before edge k shows up as `pwr_main` just after edge k and as `pwr_aux` after edge k+1. A wait condition that first holds before edge w leads to the next control change just after edge w+1. The bench applies every stimulus at a falling edge and samples at falling edges. For the mixed-acknowledge case it checks that `clk_off` is still 1 one falling edge after both acknowledges are set, and that it is 0 one falling edge later. For the random sequences, a monitor stamps each output change with its falling-edge index. The bench then checks that the stamps are strictly ordered and that no two outputs changed in the same cycle, rather than predicting the absolute cycle of each change.

// File: rtl/pd_gate_pkg.sv
package pd_gate_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_UP_AUX,
        ST_UP_WPWR,
        ST_UP_CLK,
        ST_UP_ISO,
        ST_UP_RST,
        ST_UP_SRAM,
        ST_UP_WSRAM,
        ST_UP_BUS,
        ST_DN_SRAM,
        ST_DN_WSRAM,
        ST_DN_ISO,
        ST_DN_RST,
        ST_DN_CLK,
        ST_DN_MAIN,
        ST_DN_AUX,
        ST_DN_WPWR,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       pwr_main;
        logic       pwr_aux;
        logic       iso;
        logic       rst_n;
        logic       clk_off;
        logic       guard;
        logic       done;
        logic       err;
    } seq_regs_t;

    function automatic logic is_wait_state(seq_state_e s);
        return (s == ST_UP_WPWR) || (s == ST_UP_WSRAM) ||
               (s == ST_DN_WSRAM) || (s == ST_DN_WPWR);
    endfunction

endpackage

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
    parameter int TIMEOUT_CYC = 125_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LIMIT);

endmodule

// File: rtl/pd_ack_eval.sv
module pd_ack_eval #(
    parameter int              SRAM_W        = 4,
    parameter logic [SRAM_W-1:0] SRAM_ACK_MASK = '1
) (
    input  logic              stat_ack_a,
    input  logic              stat_ack_b,
    input  logic [SRAM_W-1:0] sram_ack,
    output logic              pwr_is_on,
    output logic              pwr_is_off,
    output logic              sram_all_up,
    output logic              sram_all_down,
    output logic              sram_wait_used
);
    // a mixed pair is neither on nor off
    assign pwr_is_on  = stat_ack_a & stat_ack_b;
    assign pwr_is_off = ~stat_ack_a & ~stat_ack_b;

    generate
        if (SRAM_ACK_MASK == '0) begin : g_no_sram_ack
            assign sram_all_up    = 1'b1;
            assign sram_all_down  = 1'b1;
            assign sram_wait_used = 1'b0;
        end else begin : g_sram_ack
            logic [SRAM_W-1:0] masked;
            assign masked         = sram_ack & SRAM_ACK_MASK;
            assign sram_all_up    = (masked == '0);
            assign sram_all_down  = (masked == SRAM_ACK_MASK);
            assign sram_wait_used = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/pd_gate_seq.sv
module pd_gate_seq
    import pd_gate_pkg::*;
#(
    parameter int                SRAM_W        = 4,
    parameter logic [SRAM_W-1:0] SRAM_ACK_MASK = '1,
    parameter int                TIMEOUT_CYC   = 125_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_on,
    input  logic              stat_ack_a,
    input  logic              stat_ack_b,
    input  logic [SRAM_W-1:0] sram_ack,
    output logic              pwr_main,
    output logic              pwr_aux,
    output logic              iso_en,
    output logic              dom_rst_n,
    output logic              clk_off,
    output logic [SRAM_W-1:0] sram_pd,
    output logic              bus_guard,
    output logic              done,
    output logic              err
);
    localparam logic [SRAM_W-1:0] SRAM_ALL_PD = '1;

    seq_regs_t         r_d, r_q;
    logic [SRAM_W-1:0] sram_d, sram_q;

    logic pwr_is_on, pwr_is_off, sram_all_up, sram_all_down, sram_wait_used;
    logic wait_run, wait_expired;

    pd_ack_eval #(
        .SRAM_W        (SRAM_W),
        .SRAM_ACK_MASK (SRAM_ACK_MASK)
    ) u_ack_eval (
        .stat_ack_a     (stat_ack_a),
        .stat_ack_b     (stat_ack_b),
        .sram_ack       (sram_ack),
        .pwr_is_on      (pwr_is_on),
        .pwr_is_off     (pwr_is_off),
        .sram_all_up    (sram_all_up),
        .sram_all_down  (sram_all_down),
        .sram_wait_used (sram_wait_used)
    );

    assign wait_run = is_wait_state(r_q.st);

    pd_wait_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_wait_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (wait_expired)
    );

    always_comb begin
        r_d      = r_q;
        sram_d   = sram_q;
        r_d.done = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.err = 1'b0;
                    if (req_on) begin
                        r_d.pwr_main = 1'b1;
                        r_d.st       = ST_UP_AUX;
                    end else begin
                        r_d.guard = 1'b1;
                        r_d.st    = ST_DN_SRAM;
                    end
                end
            end

            // ---------------- power-up ----------------
            ST_UP_AUX: begin
                r_d.pwr_aux = 1'b1;
                r_d.st      = ST_UP_WPWR;
            end
            ST_UP_WPWR: begin
                if (pwr_is_on) begin
                    r_d.st = ST_UP_CLK;
                end else if (wait_expired) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_UP_CLK: begin
                r_d.clk_off = 1'b0;
                r_d.st      = ST_UP_ISO;
            end
            ST_UP_ISO: begin
                r_d.iso = 1'b0;
                r_d.st  = ST_UP_RST;
            end
            ST_UP_RST: begin
                r_d.rst_n = 1'b1;
                r_d.st    = ST_UP_SRAM;
            end
            ST_UP_SRAM: begin
                sram_d = '0;
                r_d.st = sram_wait_used ? ST_UP_WSRAM : ST_UP_BUS;
            end
            ST_UP_WSRAM: begin
                if (sram_all_up) begin
                    r_d.st = ST_UP_BUS;
                end else if (wait_expired) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_UP_BUS: begin
                r_d.guard = 1'b0;
                r_d.st    = ST_FIN;
            end

            // ---------------- power-down ----------------
            ST_DN_SRAM: begin
                sram_d = SRAM_ALL_PD;
                r_d.st = sram_wait_used ? ST_DN_WSRAM : ST_DN_ISO;
            end
            ST_DN_WSRAM: begin
                if (sram_all_down) begin
                    r_d.st = ST_DN_ISO;
                end else if (wait_expired) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_DN_ISO: begin
                r_d.iso = 1'b1;
                r_d.st  = ST_DN_RST;
            end
            ST_DN_RST: begin
                r_d.rst_n = 1'b0;
                r_d.st    = ST_DN_CLK;
            end
            ST_DN_CLK: begin
                r_d.clk_off = 1'b1;
                r_d.st      = ST_DN_MAIN;
            end
            ST_DN_MAIN: begin
                r_d.pwr_main = 1'b0;
                r_d.st       = ST_DN_AUX;
            end
            ST_DN_AUX: begin
                r_d.pwr_aux = 1'b0;
                r_d.st      = ST_DN_WPWR;
            end
            ST_DN_WPWR: begin
                if (pwr_is_off) begin
                    r_d.st = ST_FIN;
                end else if (wait_expired) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end

            ST_FIN: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.pwr_main <= 1'b0;
            r_q.pwr_aux  <= 1'b0;
            r_q.iso      <= 1'b1;
            r_q.rst_n    <= 1'b0;
            r_q.clk_off  <= 1'b1;
            r_q.guard    <= 1'b1;
            r_q.done     <= 1'b0;
            r_q.err      <= 1'b0;
            sram_q       <= SRAM_ALL_PD;
        end else begin
            r_q    <= r_d;
            sram_q <= sram_d;
        end
    end

    assign pwr_main  = r_q.pwr_main;
    assign pwr_aux   = r_q.pwr_aux;
    assign iso_en    = r_q.iso;
    assign dom_rst_n = r_q.rst_n;
    assign clk_off   = r_q.clk_off;
    assign sram_pd   = sram_q;
    assign bus_guard = r_q.guard;
    assign done      = r_q.done;
    assign err       = r_q.err;

endmodule

// File: rtl/pd_gate_seq_chk.sv
module pd_gate_seq_chk #(
    parameter int SRAM_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              pwr_main,
    input logic              pwr_aux,
    input logic              iso_en,
    input logic              dom_rst_n,
    input logic              clk_off,
    input logic [SRAM_W-1:0] sram_pd,
    input logic              bus_guard,
    input logic              done,
    input logic              err
);
    // R2: secondary switch only rises after the primary was already on
    p_aux_after_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_aux) |-> (pwr_main && $past(pwr_main)));

    // R3: clock runs only while both switches are enabled
    p_clk_needs_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_off |-> (pwr_main && pwr_aux));

    // R4: one control output moves per cycle
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pwr_main != $past(pwr_main), pwr_aux != $past(pwr_aux),
                    iso_en != $past(iso_en), dom_rst_n != $past(dom_rst_n),
                    clk_off != $past(clk_off), sram_pd != $past(sram_pd),
                    bus_guard != $past(bus_guard)}) <= 1);

    // R4 / R7: isolation is released only with the clock running
    p_iso_vs_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_en |-> !clk_off);

    // R7: reset released only while the clock runs
    p_rst_vs_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dom_rst_n |-> !clk_off);

    // R4 / R6: SRAM powered only with reset released
    p_sram_vs_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_pd != '1) |-> dom_rst_n);

    // R5 / R6: bus fence down only with all SRAM powered
    p_guard_vs_sram_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_guard |-> (sram_pd == '0));

    // R11: done is a single-cycle pulse and never with err
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_no_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err);

    // R9: err holds until a request arrives
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !req_valid) |=> err);

endmodule

bind pd_gate_seq pd_gate_seq_chk #(.SRAM_W(SRAM_W)) u_pd_gate_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .pwr_main  (pwr_main),
    .pwr_aux   (pwr_aux),
    .iso_en    (iso_en),
    .dom_rst_n (dom_rst_n),
    .clk_off   (clk_off),
    .sram_pd   (sram_pd),
    .bus_guard (bus_guard),
    .done      (done),
    .err       (err)
);

// File: tb/pd_gate_seq_bench.sv
module pd_gate_seq_bench;
    localparam int SW  = 4;
    localparam int TMO = 40;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_on = 1'b0;
    logic          ack_a = 1'b0, ack_b = 1'b0;
    logic [SW-1:0] sram_ack = '1;
    logic          pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, done, err;
    logic [SW-1:0] sram_pd;

    // second instance without SRAM acknowledge wait
    logic          n_req = 1'b0, n_on = 1'b0, n_stat = 1'b0;
    logic [SW-1:0] n_sram = '1;
    logic          n_main, n_aux, n_iso, n_rst, n_clk, n_guard, n_done, n_err;
    logic [SW-1:0] n_pd;

    pd_gate_seq #(.SRAM_W(SW), .SRAM_ACK_MASK(4'hF), .TIMEOUT_CYC(TMO)) u_pd_gate_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .stat_ack_a(ack_a), .stat_ack_b(ack_b), .sram_ack(sram_ack),
        .pwr_main(pwr_main), .pwr_aux(pwr_aux), .iso_en(iso_en), .dom_rst_n(dom_rst_n),
        .clk_off(clk_off), .sram_pd(sram_pd), .bus_guard(bus_guard), .done(done), .err(err));

    pd_gate_seq #(.SRAM_W(SW), .SRAM_ACK_MASK(4'h0), .TIMEOUT_CYC(TMO)) u_pd_gate_seq_nomask (
        .clk(clk), .rst_n(rst_n), .req_valid(n_req), .req_on(n_on),
        .stat_ack_a(n_stat), .stat_ack_b(n_stat), .sram_ack(n_sram),
        .pwr_main(n_main), .pwr_aux(n_aux), .iso_en(n_iso), .dom_rst_n(n_rst),
        .clk_off(n_clk), .sram_pd(n_pd), .bus_guard(n_guard), .done(n_done), .err(n_err));

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- monitor + acknowledge responder ----------------
    int  cyc = 0, multi = 0, dn_cnt = 0;
    int  t_main = -1, t_aux = -1, t_clk = -1, t_iso = -1, t_rst = -1, t_sram = -1;
    int  t_guard = -1, t_done = -1, t_pwr_ok = -1, t_sram_ok = -1;
    bit  done_seen = 1'b0;
    logic p_main = 0, p_aux = 0, p_iso = 0, p_rst = 0, p_clk = 0, p_guard = 0;
    logic [SW-1:0] p_sram = '0;
    bit  resp_en = 1'b1, man_en = 1'b0;
    logic man_a = 1'b0, man_b = 1'b0;
    int  dly_p = 0, dly_s = 0, pcnt = 0, scnt = 0;
    logic ptgt = 1'b0;

    always @(negedge clk) begin
        int nch;
        cyc++;
        nch = 0;
        if (pwr_main  != p_main)  begin nch++; t_main  = cyc; end
        if (pwr_aux   != p_aux)   begin nch++; t_aux   = cyc; end
        if (iso_en    != p_iso)   begin nch++; t_iso   = cyc; end
        if (dom_rst_n != p_rst)   begin nch++; t_rst   = cyc; end
        if (clk_off   != p_clk)   begin nch++; t_clk   = cyc; end
        if (sram_pd   != p_sram)  begin nch++; t_sram  = cyc; end
        if (bus_guard != p_guard) begin nch++; t_guard = cyc; end
        if (nch > 1) multi++;
        if (done) begin done_seen = 1'b1; t_done = cyc; dn_cnt++; end
        p_main = pwr_main; p_aux = pwr_aux; p_iso = iso_en; p_rst = dom_rst_n;
        p_clk = clk_off; p_sram = sram_pd; p_guard = bus_guard;

        if (man_en) begin
            ack_a = man_a;
            ack_b = man_b;
        end else if (resp_en) begin
            if (pwr_main && pwr_aux) ptgt = 1'b1;
            else if (!pwr_main && !pwr_aux) ptgt = 1'b0;
            if (ack_a != ptgt) begin
                if (pcnt >= dly_p) begin ack_a = ptgt; pcnt = 0; end
                else pcnt++;
            end else if (ack_b != ack_a) begin
                ack_b = ack_a;         // second acknowledge trails by a cycle
                t_pwr_ok = cyc;
            end
            if (sram_ack != sram_pd) begin
                if (scnt >= dly_s) begin sram_ack = sram_pd; scnt = 0; t_sram_ok = cyc; end
                else scnt++;
            end
        end
    end

    // ---------------- expected values ----------------
    function automatic logic [6+SW-1:0] exp_state(input bit on);
        // {pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd}
        return on ? {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, {SW{1'b0}}}
                  : {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {SW{1'b1}}};
    endfunction

    function automatic bit up_order_ok();
        return (t_main > 0) && (t_main < t_aux) && (t_aux < t_clk) && (t_clk < t_iso) &&
               (t_iso < t_rst) && (t_rst < t_sram) && (t_sram < t_guard) &&
               (t_guard < t_done) && (t_clk > t_pwr_ok) && (t_pwr_ok > 0) &&
               (t_guard > t_sram_ok) && (t_sram_ok > 0);
    endfunction

    function automatic bit dn_order_ok();
        return (t_guard > 0) && (t_guard < t_sram) && (t_sram < t_iso) && (t_iso < t_rst) &&
               (t_rst < t_clk) && (t_clk < t_main) && (t_main < t_aux) &&
               (t_aux < t_done) && (t_iso > t_sram_ok) && (t_sram_ok > 0) &&
               (t_done > t_pwr_ok) && (t_pwr_ok > 0);
    endfunction

    task automatic clear_trace();
        t_main = -1; t_aux = -1; t_clk = -1; t_iso = -1; t_rst = -1; t_sram = -1;
        t_guard = -1; t_done = -1; t_pwr_ok = -1; t_sram_ok = -1;
        multi = 0; dn_cnt = 0; done_seen = 1'b0;
    endtask

    task automatic pulse_req(input bit on);
        @(negedge clk);
        req_valid = 1'b1; req_on = on;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 300 && !done_seen && !err; i++) @(negedge clk);
    endtask

    bit cur_on = 1'b0;

    task automatic run_seq(input bit on, input bit inject);
        clear_trace();
        dly_p = $urandom_range(0, 12);
        dly_s = $urandom_range(0, 12);
        pulse_req(on);
        if (inject) begin
            @(negedge clk);
            req_valid = 1'b1; req_on = !on;   // must be ignored (R10)
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_end();
        repeat (2) @(negedge clk);
        chk(done_seen, on ? "R5 up done" : "R7 down done", done_seen, 1);
        chk(!err, "R9 no error", err, 0);
        if (on) chk(up_order_ok(), "R4 up order", up_order_ok(), 1);
        else    chk(dn_order_ok(), "R6 down order", dn_order_ok(), 1);
        chk(multi == 0, "R4 one change per cycle", multi, 0);
        chk({pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd} == exp_state(on),
            inject ? "R10 final state" : "R7 final state",
            {pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd}, exp_state(on));
        chk(dn_cnt == 1, "R11 done width", dn_cnt, 1);
        cur_on = on;
    endtask

    // ---------------- watchdog ----------------
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- main stimulus ----------------
    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        chk({pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd} == exp_state(1'b0),
            "R1 reset outputs", {pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd},
            exp_state(1'b0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R1 reset flags", {done, err}, 0);

        // directed: mixed acknowledge pair keeps the wait open (R3)
        clear_trace();
        man_en = 1'b1; man_a = 1'b0; man_b = 1'b0;
        pulse_req(1'b1);
        chk(pwr_main && !pwr_aux, "R2 main before aux", {pwr_main, pwr_aux}, 2);
        @(negedge clk);
        chk(pwr_main && pwr_aux, "R2 aux next edge", {pwr_main, pwr_aux}, 3);
        repeat (2) @(negedge clk);
        man_a = 1'b1;
        repeat (8) @(negedge clk);
        chk(clk_off == 1'b1, "R3 mixed a=1 b=0 holds", clk_off, 1);
        man_a = 1'b0; man_b = 1'b1;
        repeat (5) @(negedge clk);
        chk(clk_off == 1'b1, "R3 mixed a=0 b=1 holds", clk_off, 1);
        man_a = 1'b1;
        @(negedge clk);
        chk(clk_off == 1'b1, "R3 one edge after both", clk_off, 1);
        @(negedge clk);
        chk(clk_off == 1'b0, "R3 two edges after both", clk_off, 0);
        man_en = 1'b0;
        dly_s = 2;
        wait_end();
        repeat (2) @(negedge clk);
        chk(done_seen && !err, "R5 finish after mixed", {done_seen, err}, 2);
        cur_on = 1'b1;

        // constrained random sequences with optional ignored requests
        for (int i = 0; i < 24; i++) begin
            run_seq(!cur_on, ($urandom_range(0, 3) == 0));
        end

        // directed: timeout (R9)
        if (cur_on) run_seq(1'b0, 1'b0);
        clear_trace();
        man_en = 1'b1; man_a = 1'b0; man_b = 1'b0;
        pulse_req(1'b1);
        for (int i = 0; i < 100 && !err; i++) @(negedge clk);
        chk(err == 1'b1, "R9 timeout raises err", err, 1);
        chk(!done_seen, "R9 no done on timeout", done_seen, 0);
        chk({pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard} == 6'b111011,
            "R9 outputs frozen", {pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard}, 6'b111011);
        repeat (12) @(negedge clk);
        chk(err == 1'b1 && clk_off == 1'b1, "R9 err sticky", {err, clk_off}, 3);
        man_en = 1'b0;
        clear_trace();
        pulse_req(1'b0);
        chk(err == 1'b0, "R9 err cleared on request", err, 0);
        wait_end();
        repeat (2) @(negedge clk);
        chk(done_seen && !err, "R9 recovery done", {done_seen, err}, 2);
        chk({pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd} == exp_state(1'b0),
            "R9 recovery state", {pwr_main, pwr_aux, iso_en, dom_rst_n, clk_off, bus_guard, sram_pd},
            exp_state(1'b0));
        cur_on = 1'b0;
        run_seq(1'b1, 1'b0);

        // directed: zero SRAM mask skips both SRAM waits (R8)
        begin
            int lat;
            n_stat = 1'b1; n_sram = '1;          // would block a real up-wait
            @(negedge clk); n_req = 1'b1; n_on = 1'b1;
            @(negedge clk); n_req = 1'b0;
            lat = 1;
            while (!n_done && lat < 60) begin @(negedge clk); lat++; end
            chk(n_done && !n_err, "R8 up without sram wait", {n_done, n_err}, 2);
            chk(lat <= 10, "R8 up latency", lat, 9);
            chk(!n_guard && n_pd == '0, "R8 up state", {n_guard, n_pd}, 0);
            n_stat = 1'b0; n_sram = '0;          // would block a real down-wait
            @(negedge clk); n_req = 1'b1; n_on = 1'b0;
            @(negedge clk); n_req = 1'b0;
            lat = 1;
            while (!n_done && lat < 60) begin @(negedge clk); lat++; end
            chk(n_done && !n_err, "R8 down without sram wait", {n_done, n_err}, 2);
            chk(n_guard && n_iso && n_pd == '1, "R8 down state", {n_guard, n_iso}, 3);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule